// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Acknowledge Handshake

This block collects a small set of external interrupt lines plus one software-raised inter-processor interrupt and presents a single request line to one CPU. Each source is configured through a word-addressed register bus: a per-source configuration word (mask, polarity, sensitivity, 4-bit priority, 8-bit vector) and a per-source CPU destination bitmask. The block answers only for the CPU whose index is given by a parameter.

The CPU reads the acknowledge register to learn the vector of the best eligible source. That read also moves the source into service. A later write to the end-of-interrupt register retires the most recent acknowledge. Nested acknowledges are tracked as a stack of priorities. A source can interrupt only when its priority beats both the CPU threshold and the priority on top of that stack. A configuration bit chooses between forwarding an external legacy request and driving the request line from the block's own arbitration.

Top module: `intc_core`

Register word addresses: 0 configuration (bit 0 = own arbitration), 1 threshold, 2 acknowledge, 3 end-of-interrupt, 4 inter-processor dispatch, 5 inter-processor configuration, 8+2k source k configuration, 9+2k source k destination. Configuration word fields: bit 31 mask, bit 23 active-high polarity, bit 22 level sensitivity, bits 19:16 priority, bits 7:0 vector.

## Requirements
- R1: After reset every source configuration word and the inter-processor configuration word read 0x80000000 (masked). The threshold reads 15, the configuration register reads 0, and an acknowledge read returns 255.
- R2: A source configuration word reads back with the field positions listed above. A masked source is never delivered.
- R3: A source takes part in arbitration only when bit CPU_ID of its destination word is set.
- R4: A source is eligible only if its priority is strictly greater than both the threshold and the top in-service priority, with 0 used when nothing is in service. Priority 0 is therefore never delivered, and threshold 15 blocks everything.
- R5: An acknowledge read returns the vector of the eligible source with the highest priority, and equal priorities go to the lower source index. The inter-processor interrupt ranks after all sources on ties. With nothing eligible the read returns 255 and changes no state.
- R6: Each successful acknowledge pushes the winner's priority onto the in-service stack. Each end-of-interrupt write pops one entry in last-in, first-out order. A write with the stack empty has no effect.
- R7: An edge-sensitive source latches a pending flag on its inactive-to-active transition. The flag clears when that source is acknowledged. It survives while the source is masked and is delivered once the mask is cleared.
- R8: A level-sensitive source is pending while its input is active. If the input is still active after end-of-interrupt, it requests again.
- R9: With the polarity bit clear, a source is active when its input is low.
- R10: Writing a bitmask with bit CPU_ID set to the dispatch register latches the inter-processor interrupt. It is delivered with its own configuration word's vector and priority and clears when acknowledged. Dispatch words without bit CPU_ID have no effect.
- R11: While configuration bit 0 is 0, cpu_irq follows legacy_req. While it is 1, cpu_irq comes from the block's own arbitration.
- R12: In own-arbitration mode cpu_irq is high exactly when some source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_in | input | NSRC | External interrupt lines, synchronous to clk |
| legacy_req | input | 1 | Request forwarded when own arbitration is off |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench targets the strict-comparison edges. With threshold equal to a source's priority the source must stay silent, and a looser comparison would raise the line. A level source held active while it is in service must not retrigger itself. Nesting is checked by preempting a level source with a higher-priority edge source. Retiring the two in the wrong order would either bring the level request back too early or never bring it back. An edge captured while the source is masked must come out after unmasking, and a design that gates the latch with the mask would lose it. Two equal-priority sources expose a reversed tie-break, and a one-bit destination word for another CPU exposes a design that ignores the destination.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // per-source configuration word, decoded
    typedef struct packed {
        logic  mask;
        logic  pol_hi;
        logic  lvl;
        prio_t prio;
        vec_t  vec;
    } srccfg_t;

    localparam int B_MASK = 31;
    localparam int B_POL  = 23;
    localparam int B_LVL  = 22;
    localparam int B_PRIO = 16;

    localparam srccfg_t SRCCFG_RST = '{mask: 1'b1, pol_hi: 1'b0, lvl: 1'b0,
                                       prio: '0, vec: '0};
    localparam vec_t VEC_SPURIOUS = 8'hFF;

    // word addresses
    localparam int A_CFG      = 0;
    localparam int A_TPR      = 1;
    localparam int A_ACK      = 2;
    localparam int A_EOI      = 3;
    localparam int A_IPI_SEND = 4;
    localparam int A_IPI_CFG  = 5;
    localparam int A_SRC_BASE = 8;

    function automatic srccfg_t word_to_cfg(input logic [31:0] w);
        srccfg_t c;
        c.mask   = w[B_MASK];
        c.pol_hi = w[B_POL];
        c.lvl    = w[B_LVL];
        c.prio   = w[B_PRIO +: PRIO_W];
        c.vec    = w[VEC_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input srccfg_t c);
        logic [31:0] w;
        w                   = '0;
        w[B_MASK]           = c.mask;
        w[B_POL]            = c.pol_hi;
        w[B_LVL]            = c.lvl;
        w[B_PRIO +: PRIO_W] = c.prio;
        w[VEC_W-1:0]        = c.vec;
        return w;
    endfunction

endpackage

// File: rtl/intc_src.sv
module intc_src
    import intc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    src_in,
    input  srccfg_t cfg,
    input  logic    take,
    output logic    pend
);

    typedef struct packed {
        logic act;      // active level seen last cycle
        logic latched;  // captured edge
    } st_t;

    st_t  s_d, s_q;
    logic active;

    always_comb begin
        active    = cfg.pol_hi ? src_in : ~src_in;
        s_d       = s_q;
        s_d.act   = active;
        if (cfg.lvl) begin
            s_d.latched = 1'b0;
        end else begin
            // a fresh edge wins over a same-cycle acknowledge
            s_d.latched = (s_q.latched & ~take) | (active & ~s_q.act);
        end
        pend = cfg.lvl ? active : s_q.latched;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int N  = 9,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic  [N-1:0] req,
    input  prio_t [N-1:0] prio,
    input  vec_t  [N-1:0] vec,
    input  prio_t         floor_prio,
    output logic          hit,
    output logic [IW-1:0] idx,
    output prio_t         win_prio,
    output vec_t          win_vec
);

    // strict greater-than against the running best keeps the lowest index on ties
    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        win_prio = floor_prio;
        win_vec  = VEC_SPURIOUS;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (prio[i] > win_prio)) begin
                hit      = 1'b1;
                idx      = IW'(i);
                win_prio = prio[i];
                win_vec  = vec[i];
            end
        end
    end

endmodule

// File: rtl/intc_isr_stack.sv
module intc_isr_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  prio_t           push_prio,
    input  logic            pop,
    output prio_t           top_prio,
    output logic [SP_W-1:0] sp
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        prio_t [DEPTH-1:0] ent;
        logic  [SP_W-1:0]  sp;
    } st_t;

    st_t           s_d, s_q;
    logic [IW-1:0] wr_ix;
    logic [IW-1:0] rd_ix;

    always_comb begin
        s_d   = s_q;
        wr_ix = s_q.sp[IW-1:0];
        rd_ix = IW'(s_q.sp - 1'b1);
        if (push && (s_q.sp < SP_W'(DEPTH))) begin
            s_d.ent[wr_ix] = push_prio;
            s_d.sp         = s_q.sp + 1'b1;
        end else if (pop && (s_q.sp != '0)) begin
            s_d.sp = s_q.sp - 1'b1;
        end
        top_prio = (s_q.sp == '0) ? '0 : s_q.ent[rd_ix];
        sp       = s_q.sp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int NCPU      = 2,
    parameter int CPU_ID    = 0,
    parameter int ISR_DEPTH = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   src_in,
    input  logic              legacy_req,
    output logic              cpu_irq
);

    localparam int NCAND = NSRC + 1;
    localparam int CIW   = $clog2(NCAND);
    localparam int SP_W  = $clog2(ISR_DEPTH + 1);
    localparam int SIW   = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic                         arb_only;
        prio_t                        tpr;
        srccfg_t [NSRC-1:0]           scfg;
        logic    [NSRC-1:0][NCPU-1:0] dest;
        srccfg_t                      ipi_cfg;
        logic                         ipi_pend;
    } regs_t;

    localparam regs_t REGS_RST = '{arb_only: 1'b0, tpr: '1,
                                   scfg: {NSRC{SRCCFG_RST}}, dest: '0,
                                   ipi_cfg: SRCCFG_RST, ipi_pend: 1'b0};

    regs_t regs_d, regs_q;

    // decode
    logic [ADDR_W-1:0] src_off;
    logic              in_src;
    logic [SIW-1:0]    src_sel;
    logic              is_dest;
    logic              ack_fire;
    logic              eoi_fire;

    // arbitration
    logic  [NSRC-1:0]  pend;
    logic  [NSRC-1:0]  take;
    logic  [NCAND-1:0] cand_req;
    prio_t [NCAND-1:0] cand_prio;
    vec_t  [NCAND-1:0] cand_vec;
    prio_t             isr_top;
    prio_t             floor_prio;
    logic              hit;
    logic  [CIW-1:0]   win_idx;
    prio_t             win_prio;
    vec_t              win_vec;
    logic  [SP_W-1:0]  sp;

    always_comb begin
        src_off  = bus_addr - ADDR_W'(A_SRC_BASE);
        in_src   = (bus_addr >= ADDR_W'(A_SRC_BASE)) && (src_off < ADDR_W'(2 * NSRC));
        src_sel  = src_off[SIW:1];
        is_dest  = src_off[0];
        ack_fire = bus_rd && (bus_addr == ADDR_W'(A_ACK)) && hit;
        eoi_fire = bus_wr && (bus_addr == ADDR_W'(A_EOI));
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            intc_src u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_in (src_in[g]),
                .cfg    (regs_q.scfg[g]),
                .take   (take[g]),
                .pend   (pend[g])
            );
            assign take[g]      = ack_fire && (win_idx == CIW'(g));
            assign cand_req[g]  = pend[g] && !regs_q.scfg[g].mask && regs_q.dest[g][CPU_ID];
            assign cand_prio[g] = regs_q.scfg[g].prio;
            assign cand_vec[g]  = regs_q.scfg[g].vec;
        end
    endgenerate

    assign cand_req[NSRC]  = regs_q.ipi_pend && !regs_q.ipi_cfg.mask;
    assign cand_prio[NSRC] = regs_q.ipi_cfg.prio;
    assign cand_vec[NSRC]  = regs_q.ipi_cfg.vec;
    assign floor_prio      = (regs_q.tpr > isr_top) ? regs_q.tpr : isr_top;

    intc_arb #(.N(NCAND), .IW(CIW)) u_arb (
        .req        (cand_req),
        .prio       (cand_prio),
        .vec        (cand_vec),
        .floor_prio (floor_prio),
        .hit        (hit),
        .idx        (win_idx),
        .win_prio   (win_prio),
        .win_vec    (win_vec)
    );

    intc_isr_stack #(.DEPTH(ISR_DEPTH), .SP_W(SP_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_fire),
        .push_prio (win_prio),
        .pop       (eoi_fire),
        .top_prio  (isr_top),
        .sp        (sp)
    );

    // next register state
    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(A_CFG):      regs_d.arb_only = bus_wdata[0];
                ADDR_W'(A_TPR):      regs_d.tpr      = bus_wdata[PRIO_W-1:0];
                ADDR_W'(A_IPI_CFG):  regs_d.ipi_cfg  = word_to_cfg(bus_wdata);
                ADDR_W'(A_IPI_SEND): if (bus_wdata[CPU_ID]) regs_d.ipi_pend = 1'b1;
                default: begin
                    if (in_src) begin
                        if (is_dest) regs_d.dest[src_sel] = bus_wdata[NCPU-1:0];
                        else         regs_d.scfg[src_sel] = word_to_cfg(bus_wdata);
                    end
                end
            endcase
        end
        if (ack_fire && (win_idx == CIW'(NSRC))) begin
            regs_d.ipi_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CFG):     bus_rdata[0]            = regs_q.arb_only;
            ADDR_W'(A_TPR):     bus_rdata[PRIO_W-1:0]   = regs_q.tpr;
            ADDR_W'(A_ACK):     bus_rdata[VEC_W-1:0]    = win_vec;
            ADDR_W'(A_IPI_CFG): bus_rdata               = cfg_to_word(regs_q.ipi_cfg);
            default: begin
                if (in_src) begin
                    if (is_dest) bus_rdata[NCPU-1:0] = regs_q.dest[src_sel];
                    else         bus_rdata           = cfg_to_word(regs_q.scfg[src_sel]);
                end
            end
        endcase
    end

    assign cpu_irq = regs_q.arb_only ? hit : legacy_req;

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
    import intc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16,
    parameter int SP_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              ack_fire,
    input logic              eoi_fire,
    input logic              hit,
    input prio_t             win_prio,
    input prio_t             isr_top,
    input prio_t             tpr,
    input logic [SP_W-1:0]   sp
);

    p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(A_ACK)) && !hit) |-> (bus_rdata == 32'h0000_00FF));

    p_above_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((win_prio > isr_top) && (win_prio > tpr)));

    p_nest_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (isr_top == $past(win_prio)));

    p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && (sp != '0)) |=> (sp == $past(sp) - 1'b1));

    p_eoi_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && (sp == '0)) |=> (sp == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |-> (sp < SP_W'(DEPTH)));

endmodule

bind intc_core intc_core_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (ISR_DEPTH),
    .SP_W   (SP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ack_fire  (ack_fire),
    .eoi_fire  (eoi_fire),
    .hit       (hit),
    .win_prio  (win_prio),
    .isr_top   (isr_top),
    .tpr       (regs_q.tpr),
    .sp        (sp)
);

// File: tb/intc_core_tb.sv
`timescale 1ns/1ps
module intc_core_tb;

    localparam int NSRC = 8;
    localparam int AW   = 6;

    localparam logic [1:0] OP_W = 2'd0;  // register write
    localparam logic [1:0] OP_R = 2'd1;  // register read and compare
    localparam logic [1:0] OP_S = 2'd2;  // drive src_in
    localparam logic [1:0] OP_I = 2'd3;  // compare cpu_irq

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  rq;
    } step_t;

    localparam int NSTEP = 50;

    // addresses: 0 cfg, 1 threshold, 2 ack, 3 eoi, 14/15 src3, 18/19 src5
    localparam step_t STEPS [NSTEP] = '{
        '{OP_W, 6'd0,  32'd1,          32'd0,          4'd11}, // R11 own arbitration on
        '{OP_W, 6'd1,  32'd0,          32'd0,          4'd4},
        '{OP_W, 6'd14, 32'h00C80003,   32'd0,          4'd2},  // src3 level, high, prio 8
        '{OP_W, 6'd15, 32'd1,          32'd0,          4'd3},
        '{OP_R, 6'd14, 32'd0,          32'h00C80003,   4'd2},  // R2 readback
        '{OP_S, 6'd0,  32'h08,         32'd0,          4'd8},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd12}, // R12
        '{OP_R, 6'd2,  32'd0,          32'd3,          4'd5},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd4},  // R4 own prio blocks
        '{OP_W, 6'd3,  32'd0,          32'd0,          4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd8},  // R8 re-request
        '{OP_S, 6'd0,  32'h00,         32'd0,          4'd8},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd8},
        '{OP_W, 6'd18, 32'h008A0025,   32'd0,          4'd7},  // src5 edge prio 10
        '{OP_W, 6'd19, 32'd1,          32'd0,          4'd7},
        '{OP_S, 6'd0,  32'h20,         32'd0,          4'd7},
        '{OP_S, 6'd0,  32'h00,         32'd0,          4'd7},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd7},  // R7 latched
        '{OP_R, 6'd2,  32'd0,          32'h25,         4'd7},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd7},
        '{OP_W, 6'd3,  32'd0,          32'd0,          4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd7},  // R7 cleared by ack
        '{OP_W, 6'd18, 32'h808A0025,   32'd0,          4'd2},  // mask src5
        '{OP_S, 6'd0,  32'h20,         32'd0,          4'd7},
        '{OP_S, 6'd0,  32'h00,         32'd0,          4'd7},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd2},  // R2 masked
        '{OP_W, 6'd18, 32'h008A0025,   32'd0,          4'd7},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd7},  // R7 kept across mask
        '{OP_R, 6'd2,  32'd0,          32'h25,         4'd7},
        '{OP_W, 6'd3,  32'd0,          32'd0,          4'd6},
        '{OP_S, 6'd0,  32'h08,         32'd0,          4'd6},
        '{OP_R, 6'd2,  32'd0,          32'd3,          4'd6},
        '{OP_S, 6'd0,  32'h28,         32'd0,          4'd6},
        '{OP_S, 6'd0,  32'h08,         32'd0,          4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd4},  // R4 preempt 10 > 8
        '{OP_R, 6'd2,  32'd0,          32'h25,         4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd6},
        '{OP_W, 6'd3,  32'd0,          32'd0,          4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd6},  // R6 src3 still in service
        '{OP_W, 6'd3,  32'd0,          32'd0,          4'd6},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd6},
        '{OP_W, 6'd1,  32'd9,          32'd0,          4'd4},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd4},
        '{OP_R, 6'd2,  32'd0,          32'hFF,         4'd5},  // R5 empty ack
        '{OP_W, 6'd1,  32'd8,          32'd0,          4'd4},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd4},  // R4 equal is not enough
        '{OP_W, 6'd1,  32'd7,          32'd0,          4'd4},
        '{OP_I, 6'd0,  32'd0,          32'd1,          4'd4},
        '{OP_S, 6'd0,  32'h00,         32'd0,          4'd8},
        '{OP_I, 6'd0,  32'd0,          32'd0,          4'd8}
    };

    logic            clk;
    logic            rst_n;
    logic [AW-1:0]   bus_addr;
    logic            bus_wr;
    logic            bus_rd;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_in;
    logic            legacy_req;
    logic            cpu_irq;

    int checks;
    int errors;

    intc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_in     (src_in),
        .legacy_req (legacy_req),
        .cpu_irq    (cpu_irq)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input int rq);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 chk(rq, bus_rdata, exp);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_in = v;
    endtask

    task automatic irq_chk(input logic exp, input int rq);
        @(negedge clk);
        #1 chk(rq, {31'd0, cpu_irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks     = 0;
        errors     = 0;
        rst_n      = 1'b0;
        bus_addr   = '0;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_wdata  = '0;
        src_in     = '0;
        legacy_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(6'd8,  32'h80000000, 1);
        rd_chk(6'd22, 32'h80000000, 1);
        rd_chk(6'd5,  32'h80000000, 1);
        rd_chk(6'd1,  32'd15, 1);
        rd_chk(6'd0,  32'd0, 1);
        rd_chk(6'd2,  32'hFF, 1);
        irq_chk(1'b0, 1);

        // vector table
        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                OP_W:    wr(STEPS[i].addr, STEPS[i].data);
                OP_R:    rd_chk(STEPS[i].addr, STEPS[i].exp, int'(STEPS[i].rq));
                OP_S:    set_src(STEPS[i].data[NSRC-1:0]);
                default: irq_chk(STEPS[i].exp[0], int'(STEPS[i].rq));
            endcase
        end

        // R5 tie between src3 and src6 at priority 8 goes to src3
        wr(6'd1, 32'd0);
        wr(6'd20, 32'h00C80006);
        wr(6'd21, 32'd1);
        set_src(8'h48);
        rd_chk(6'd2, 32'd3, 5);
        wr(6'd3, 32'd0);
        rd_chk(6'd2, 32'd3, 5);
        set_src(8'h40);
        wr(6'd3, 32'd0);
        rd_chk(6'd2, 32'd6, 5);
        set_src(8'h00);
        wr(6'd3, 32'd0);
        irq_chk(1'b0, 5);

        // R3 destination for another CPU only
        wr(6'd21, 32'd2);
        set_src(8'h40);
        irq_chk(1'b0, 3);
        rd_chk(6'd2, 32'hFF, 3);
        set_src(8'h00);

        // R9 active-low level source
        set_src(8'h04);
        wr(6'd12, 32'h00490002);
        wr(6'd13, 32'd1);
        irq_chk(1'b0, 9);
        set_src(8'h00);
        irq_chk(1'b1, 9);
        rd_chk(6'd2, 32'd2, 9);
        set_src(8'h04);
        wr(6'd3, 32'd0);
        irq_chk(1'b0, 9);

        // R10 inter-processor interrupt
        wr(6'd5, 32'h000F0040);
        rd_chk(6'd5, 32'h000F0040, 10);
        wr(6'd4, 32'd2);
        irq_chk(1'b0, 10);
        wr(6'd4, 32'd1);
        irq_chk(1'b1, 10);
        rd_chk(6'd2, 32'h40, 10);
        irq_chk(1'b0, 10);
        wr(6'd3, 32'd0);
        irq_chk(1'b0, 10);

        // R11 legacy forwarding
        wr(6'd0, 32'd0);
        set_src(8'h0C);
        irq_chk(1'b0, 11);
        legacy_req = 1'b1;
        irq_chk(1'b1, 11);
        legacy_req = 1'b0;
        wr(6'd0, 32'd1);
        irq_chk(1'b1, 11);
        rd_chk(6'd2, 32'd3, 11);
        set_src(8'h04);
        wr(6'd3, 32'd0);
        irq_chk(1'b0, 12);

        // R6 eoi on empty stack has no effect
        wr(6'd3, 32'd0);
        set_src(8'h0C);
        rd_chk(6'd2, 32'd3, 6);
        wr(6'd3, 32'd0);
        irq_chk(1'b1, 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule